// File: doc/BRIEF.md
# Bulk Command Stream Register Decoder

This block sits behind a bulk-transfer byte pipe and turns the command stream arriving on it into register updates and copy requests. Bytes come in one per cycle over a valid/ready pair, with a marker on the final byte of each transfer. Every command opens with the prefix byte 0xAF and an opcode byte. The register-write opcode carries an index and a value for a 256-entry byte register file. The copy opcode carries a seven-byte payload, which is handed to a downstream copy engine over its own valid/ready request port.

The low part of the register file holds video timing and frame layout settings. These settings can be staged: a lock write to the control index stops the staged range from reaching the active copies. The matching unlock write moves every staged value into the active registers at once, so a mode change never shows a half-updated timing set. The block decodes a few fields from the active registers for the neighbouring display logic: the two frame base addresses, the pixel clock and the colour depth select.

A lone prefix at the end of a transfer is padding and is dropped silently. An opcode the parser does not know raises a sticky error flag. The parser then discards bytes until the next prefix.

Top module: `cmd_stream_decoder`

## Requirements
- R1: While waiting for a command, the parser accepts a byte and discards it unless it is 0xAF. A discarded byte sets the error flag. A 0xAF byte that is not a lone trailing prefix makes the next byte the opcode.
- R2: The sequence 0xAF, 0x20, index, value writes value to that index. When the entry is not held back by staging, the read port shows the new value in the cycle after the value byte is accepted.
- R3: Writing 0x00 to index 0xFF raises `locked` in the next cycle. Writing 0xFF to index 0xFF clears it in the next cycle.
- R4: While `locked` is high, writes to indices below STAGED_REGS (default 0x30) leave the read port and the decoded outputs unchanged. Writes to indices at or above STAGED_REGS take effect at once.
- R5: The unlock write copies every staged value into the active registers. The copied values are visible in the cycle after the unlock value byte is accepted.
- R6: The sequence 0xAF, 0x6A, then seven payload bytes produces a copy request. The first three payload bytes form `cp_src`, most significant first. The fourth byte is `cp_count`. The last three form `cp_dst`, most significant first. `cp_valid` rises in the cycle after the seventh payload byte is accepted.
- R7: While `cp_valid` is high, `in_ready` is low and the request fields hold steady. `cp_valid` falls in the cycle after `cp_valid` and `cp_ready` are both high.
- R8: A 0xAF byte presented with `in_last` high while waiting for a command is discarded. It leaves the error flag unchanged, and the next command parses normally.
- R9: An opcode other than 0x20 or 0x6A sets the error flag and returns the parser to waiting for 0xAF. The non-prefix bytes that follow change no register.
- R10: Once set, the error flag stays high until reset.
- R11: `fb16_base` is {reg 0x20, reg 0x21, reg 0x22} and `fb8_base` is {reg 0x26, reg 0x27, reg 0x28}. `pix_clk_5k` is {reg 0x1C, reg 0x1B}. `depth16` is high when reg 0x00 is zero. All four are decoded from the active registers.
- R12: After reset all registers are zero, `locked`, `err` and `cp_valid` are low, and `in_ready` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Stream byte valid |
| in_data | input | 8 | Stream byte |
| in_last | input | 1 | Byte is the last one of its transfer |
| in_ready | output | 1 | Parser can take a byte |
| rd_addr | input | 8 | Active register read index |
| rd_data | output | 8 | Active register value at rd_addr |
| locked | output | 1 | Staged registers are held back |
| err | output | 1 | Sticky framing error |
| fb16_base | output | 24 | 16bpp frame base address |
| fb8_base | output | 24 | 8bpp frame base address |
| pix_clk_5k | output | 16 | Pixel clock in 5 kHz units |
| depth16 | output | 1 | Colour depth select is 16 bits per pixel |
| cp_valid | output | 1 | Copy request valid |
| cp_ready | input | 1 | Copy engine accepts the request |
| cp_src | output | 24 | Copy source address |
| cp_count | output | 8 | Copy pixel count |
| cp_dst | output | 24 | Copy destination address |

## Verification
Two events can meet in one cycle: the copy engine accepting a pending request, and a new stream byte that has been waiting behind the resulting stall. The bench provokes this by presenting the next prefix byte while the copy request is still held. It keeps `cp_ready` low for several cycles and then raises it for one cycle. The checks are that `in_ready` stays low during the whole hold, including the handshake cycle, that the fields do not move, and that the waiting byte is taken only in the following cycle. The register write that follows must then land correctly.

// File: rtl/cmd_pkg.sv
// Shared constants and types for the command stream decoder.
// Assumes byte-wide stream and register indices of eight bits.
package cmd_pkg;
    localparam logic [7:0] PREFIX_BYTE = 8'hAF;
    localparam logic [7:0] OP_REG_WR   = 8'h20;
    localparam logic [7:0] OP_COPY     = 8'h6A;

    localparam logic [7:0] CTRL_IDX    = 8'hFF;
    localparam logic [7:0] CTRL_LOCK   = 8'h00;
    localparam logic [7:0] CTRL_OPEN   = 8'hFF;

    localparam logic [7:0] IDX_DEPTH   = 8'h00;
    localparam logic [7:0] IDX_PCLK_LO = 8'h1B;
    localparam logic [7:0] IDX_PCLK_HI = 8'h1C;
    localparam logic [7:0] IDX_B16_HI  = 8'h20;
    localparam logic [7:0] IDX_B16_MID = 8'h21;
    localparam logic [7:0] IDX_B16_LO  = 8'h22;
    localparam logic [7:0] IDX_B8_HI   = 8'h26;
    localparam logic [7:0] IDX_B8_MID  = 8'h27;
    localparam logic [7:0] IDX_B8_LO   = 8'h28;

    localparam int ADDR_BYTES = 3;
    localparam int PAY_BYTES  = 2 * ADDR_BYTES + 1;
    localparam int PAY_BITS   = 8 * PAY_BYTES;

    typedef enum logic [2:0] {
        PS_HUNT,
        PS_OPCODE,
        PS_INDEX,
        PS_VALUE,
        PS_PAYLOAD
    } parse_state_t;
endpackage

// File: rtl/cmd_parser.sv
// Byte-level command framer. It hunts for the prefix, decodes the opcode
// and emits a one-cycle register write or a copy payload load.
// Assumes the downstream copy port raises stall while a request is pending.
module cmd_parser
    import cmd_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_valid,
    input  logic [7:0]          in_data,
    input  logic                in_last,
    output logic                in_ready,
    input  logic                stall,
    output logic                wr_en,
    output logic [7:0]          wr_addr,
    output logic [7:0]          wr_data,
    output logic                cp_load,
    output logic [PAY_BITS-1:0] cp_payload,
    output logic                err
);
    localparam int CNT_W = $clog2(PAY_BYTES);
    localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(PAY_BYTES - 1);

    parse_state_t        state_q;
    logic [7:0]          idx_q;
    logic [CNT_W-1:0]    cnt_q;
    logic [PAY_BITS-1:0] pay_q;
    logic                err_q;
    logic                take;

    // Accept bytes whenever no copy request is pending.
    assign in_ready = !stall;
    assign take     = in_valid && in_ready;

    // Register write strobe on the value byte.
    assign wr_en   = take && (state_q == PS_VALUE);
    assign wr_addr = idx_q;
    assign wr_data = in_data;

    // Copy load strobe on the final payload byte.
    assign cp_load    = take && (state_q == PS_PAYLOAD) && (cnt_q == CNT_LAST);
    assign cp_payload = {pay_q[PAY_BITS-9:0], in_data};
    assign err        = err_q;

    // Framing state machine with sticky error capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= PS_HUNT;
            idx_q   <= '0;
            cnt_q   <= '0;
            pay_q   <= '0;
            err_q   <= 1'b0;
        end else if (take) begin
            unique case (state_q)
                PS_HUNT: begin
                    if (in_data == PREFIX_BYTE) begin
                        if (!in_last) state_q <= PS_OPCODE;
                    end else begin
                        err_q <= 1'b1;
                    end
                end
                PS_OPCODE: begin
                    if (in_data == OP_REG_WR) begin
                        state_q <= PS_INDEX;
                    end else if (in_data == OP_COPY) begin
                        state_q <= PS_PAYLOAD;
                        cnt_q   <= '0;
                    end else begin
                        state_q <= PS_HUNT;
                        err_q   <= 1'b1;
                    end
                end
                PS_INDEX: begin
                    idx_q   <= in_data;
                    state_q <= PS_VALUE;
                end
                PS_VALUE: begin
                    state_q <= PS_HUNT;
                end
                PS_PAYLOAD: begin
                    pay_q <= {pay_q[PAY_BITS-9:0], in_data};
                    cnt_q <= cnt_q + 1'b1;
                    if (cnt_q == CNT_LAST) state_q <= PS_HUNT;
                end
                default: state_q <= PS_HUNT;
            endcase
        end
    end
endmodule

// File: rtl/staged_regfile.sv
// 256-entry byte register file. Indices below STAGED_REGS have a shadow
// copy; while locked only the shadow is written. The unlock write moves
// all shadows into the active copies in one cycle.
// Assumes STAGED_REGS covers the decoded timing and base indices (> 0x28).
module staged_regfile
    import cmd_pkg::*;
#(
    parameter int STAGED_REGS = 48
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [7:0]  wr_addr,
    input  logic [7:0]  wr_data,
    input  logic [7:0]  rd_addr,
    output logic [7:0]  rd_data,
    output logic        locked,
    output logic [23:0] fb16_base,
    output logic [23:0] fb8_base,
    output logic [15:0] pix_clk_5k,
    output logic        depth16
);
    localparam int NREGS = 256;

    logic [7:0] act_q [NREGS];
    logic [7:0] shd_q [STAGED_REGS];
    logic       lock_q;
    logic       ctrl_wr;
    logic       do_lock;
    logic       do_open;

    assign ctrl_wr = wr_en && (wr_addr == CTRL_IDX);
    assign do_lock = ctrl_wr && (wr_data == CTRL_LOCK);
    assign do_open = ctrl_wr && (wr_data == CTRL_OPEN);

    // Lock state follows the control register writes.
    always_ff @(posedge clk) begin
        if (!rst_n)       lock_q <= 1'b0;
        else if (do_lock) lock_q <= 1'b1;
        else if (do_open) lock_q <= 1'b0;
    end

    // Staged entries: shadow always written, active written when open or on unlock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGED_REGS; i++) begin
                shd_q[i] <= '0;
                act_q[i] <= '0;
            end
        end else begin
            for (int i = 0; i < STAGED_REGS; i++) begin
                if (wr_en && (wr_addr == 8'(i))) shd_q[i] <= wr_data;
                if (do_open)
                    act_q[i] <= shd_q[i];
                else if (wr_en && !lock_q && (wr_addr == 8'(i)))
                    act_q[i] <= wr_data;
            end
        end
    end

    // Unstaged entries: written directly regardless of lock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = STAGED_REGS; i < NREGS; i++) act_q[i] <= '0;
        end else begin
            for (int i = STAGED_REGS; i < NREGS; i++)
                if (wr_en && (wr_addr == 8'(i))) act_q[i] <= wr_data;
        end
    end

    // Read port and decoded fields for neighbouring logic.
    assign rd_data    = act_q[rd_addr];
    assign locked     = lock_q;
    assign fb16_base  = {act_q[IDX_B16_HI], act_q[IDX_B16_MID], act_q[IDX_B16_LO]};
    assign fb8_base   = {act_q[IDX_B8_HI], act_q[IDX_B8_MID], act_q[IDX_B8_LO]};
    assign pix_clk_5k = {act_q[IDX_PCLK_HI], act_q[IDX_PCLK_LO]};
    assign depth16    = (act_q[IDX_DEPTH] == 8'h00);
endmodule

// File: rtl/copy_req_port.sv
// Holds a captured copy payload and presents it with valid/ready.
// Assumes no new load arrives while a request is pending (parser stalls).
module copy_req_port
    import cmd_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load,
    input  logic [PAY_BITS-1:0] payload,
    input  logic                cp_ready,
    output logic                cp_valid,
    output logic [23:0]         cp_src,
    output logic [7:0]          cp_count,
    output logic [23:0]         cp_dst
);
    localparam int AB = 8 * ADDR_BYTES;

    logic                valid_q;
    logic [PAY_BITS-1:0] hold_q;

    // Capture the payload and keep valid until the handshake completes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            hold_q  <= '0;
        end else if (load) begin
            valid_q <= 1'b1;
            hold_q  <= payload;
        end else if (valid_q && cp_ready) begin
            valid_q <= 1'b0;
        end
    end

    assign cp_valid = valid_q;
    assign cp_src   = hold_q[PAY_BITS-1 -: AB];
    assign cp_count = hold_q[AB +: 8];
    assign cp_dst   = hold_q[AB-1:0];
endmodule

// File: rtl/cmd_stream_decoder.sv
// Top level: framer, staged register file and copy request port.
// Assumes one byte per cycle at most and a single clock domain.
module cmd_stream_decoder
    import cmd_pkg::*;
#(
    parameter int STAGED_REGS = 48
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        in_valid,
    input  logic [7:0]  in_data,
    input  logic        in_last,
    output logic        in_ready,
    input  logic [7:0]  rd_addr,
    output logic [7:0]  rd_data,
    output logic        locked,
    output logic        err,
    output logic [23:0] fb16_base,
    output logic [23:0] fb8_base,
    output logic [15:0] pix_clk_5k,
    output logic        depth16,
    output logic        cp_valid,
    input  logic        cp_ready,
    output logic [23:0] cp_src,
    output logic [7:0]  cp_count,
    output logic [23:0] cp_dst
);
    logic                w_en;
    logic [7:0]          w_addr;
    logic [7:0]          w_data;
    logic                c_load;
    logic [PAY_BITS-1:0] c_pay;

    cmd_parser u_parse (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_data(in_data), .in_last(in_last),
        .in_ready(in_ready), .stall(cp_valid),
        .wr_en(w_en), .wr_addr(w_addr), .wr_data(w_data),
        .cp_load(c_load), .cp_payload(c_pay), .err(err)
    );

    staged_regfile #(.STAGED_REGS(STAGED_REGS)) u_regs (
        .clk(clk), .rst_n(rst_n),
        .wr_en(w_en), .wr_addr(w_addr), .wr_data(w_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .locked(locked),
        .fb16_base(fb16_base), .fb8_base(fb8_base),
        .pix_clk_5k(pix_clk_5k), .depth16(depth16)
    );

    copy_req_port u_copy (
        .clk(clk), .rst_n(rst_n),
        .load(c_load), .payload(c_pay), .cp_ready(cp_ready),
        .cp_valid(cp_valid), .cp_src(cp_src),
        .cp_count(cp_count), .cp_dst(cp_dst)
    );
endmodule

// File: rtl/cmd_stream_decoder_chk.sv
// Property checker for the command stream decoder, bound to the top.
module cmd_stream_decoder_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        in_ready,
    input logic        locked,
    input logic        err,
    input logic [23:0] fb16_base,
    input logic [23:0] fb8_base,
    input logic [15:0] pix_clk_5k,
    input logic        cp_valid,
    input logic        cp_ready,
    input logic [23:0] cp_src,
    input logic [7:0]  cp_count,
    input logic [23:0] cp_dst,
    input logic        w_en,
    input logic [7:0]  w_addr,
    input logic [7:0]  w_data
);
    // R7
    stall_while_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cp_valid |-> !in_ready);

    // R7
    hold_request_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cp_valid && !cp_ready |=> cp_valid && $stable(cp_src) && $stable(cp_count) && $stable(cp_dst));

    // R7
    release_request_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cp_valid && cp_ready |=> !cp_valid);

    // R10
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err |=> err);

    // R3
    lock_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        w_en && w_addr == 8'hFF && w_data == 8'h00 |=> locked);

    // R3
    lock_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        w_en && w_addr == 8'hFF && w_data == 8'hFF |=> !locked);

    // R4
    staged_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        locked && w_en && w_addr != 8'hFF |=> $stable(fb16_base) && $stable(fb8_base) && $stable(pix_clk_5k));
endmodule

bind cmd_stream_decoder cmd_stream_decoder_chk u_chk (
    .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .locked(locked), .err(err),
    .fb16_base(fb16_base), .fb8_base(fb8_base), .pix_clk_5k(pix_clk_5k),
    .cp_valid(cp_valid), .cp_ready(cp_ready), .cp_src(cp_src),
    .cp_count(cp_count), .cp_dst(cp_dst),
    .w_en(w_en), .w_addr(w_addr), .w_data(w_data)
);

// File: tb/sim_cmd_stream_decoder.sv
`timescale 1ns/1ps
module sim_cmd_stream_decoder;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [7:0]  in_data = 8'h00;
    logic        in_last = 1'b0;
    logic        in_ready;
    logic [7:0]  rd_addr = 8'h00;
    logic [7:0]  rd_data;
    logic        locked, err, depth16, cp_valid;
    logic        cp_ready = 1'b0;
    logic [23:0] fb16_base, fb8_base, cp_src, cp_dst;
    logic [15:0] pix_clk_5k;
    logic [7:0]  cp_count;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    cmd_stream_decoder u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .in_last(in_last), .in_ready(in_ready), .rd_addr(rd_addr),
        .rd_data(rd_data), .locked(locked), .err(err),
        .fb16_base(fb16_base), .fb8_base(fb8_base), .pix_clk_5k(pix_clk_5k),
        .depth16(depth16), .cp_valid(cp_valid), .cp_ready(cp_ready),
        .cp_src(cp_src), .cp_count(cp_count), .cp_dst(cp_dst)
    );

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    // Present one byte from a falling edge until it is taken at a rising edge.
    task automatic send(input logic [7:0] b, input logic last);
        in_valid = 1'b1;
        in_data  = b;
        in_last  = last;
        while (!in_ready) @(negedge clk);
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        in_last  = 1'b0;
    endtask

    task automatic reg_wr(input logic [7:0] idx, input logic [7:0] val);
        send(8'hAF, 1'b0);
        send(8'h20, 1'b0);
        send(idx, 1'b0);
        send(val, 1'b0);
    endtask

    task automatic read_chk(input string req, input logic [7:0] idx, input logic [7:0] exp);
        rd_addr = idx;
        #1;
        check(req, {24'h0, rd_data}, {24'h0, exp});
    endtask

    task automatic t_reset();
        check("R12 in_ready", {31'h0, in_ready}, 32'h1);
        check("R12 locked", {31'h0, locked}, 32'h0);
        check("R12 err", {31'h0, err}, 32'h0);
        check("R12 cp_valid", {31'h0, cp_valid}, 32'h0);
        check("R12 fb16_base", {8'h0, fb16_base}, 32'h0);
        check("R11 depth16 at reset", {31'h0, depth16}, 32'h1);
        read_chk("R12 reg 0x40", 8'h40, 8'h00);
    endtask

    task automatic t_write();
        reg_wr(8'h40, 8'h5A);
        read_chk("R2 unstaged write", 8'h40, 8'h5A);
        reg_wr(8'h05, 8'hA5);
        read_chk("R2 staged index while open", 8'h05, 8'hA5);
    endtask

    task automatic t_stage();
        reg_wr(8'hFF, 8'h00);
        check("R3 lock", {31'h0, locked}, 32'h1);
        reg_wr(8'h20, 8'h12);
        reg_wr(8'h21, 8'h34);
        reg_wr(8'h22, 8'h56);
        check("R4 base held while locked", {8'h0, fb16_base}, 32'h0);
        read_chk("R4 reg 0x21 held", 8'h21, 8'h00);
        reg_wr(8'h40, 8'h77);
        read_chk("R4 unstaged immediate while locked", 8'h40, 8'h77);
        reg_wr(8'hFF, 8'hFF);
        check("R3 unlock", {31'h0, locked}, 32'h0);
        check("R5 base after unlock", {8'h0, fb16_base}, 32'h123456);
        read_chk("R5 reg 0x21 after unlock", 8'h21, 8'h34);
    endtask

    task automatic t_decode();
        reg_wr(8'h1B, 8'h34);
        reg_wr(8'h1C, 8'h12);
        check("R11 pixel clock", {16'h0, pix_clk_5k}, 32'h1234);
        reg_wr(8'h26, 8'h0A);
        reg_wr(8'h27, 8'h0B);
        reg_wr(8'h28, 8'h0C);
        check("R11 8bpp base", {8'h0, fb8_base}, 32'h0A0B0C);
        reg_wr(8'h00, 8'h01);
        check("R11 depth not 16", {31'h0, depth16}, 32'h0);
        reg_wr(8'h00, 8'h00);
        check("R11 depth 16", {31'h0, depth16}, 32'h1);
    endtask

    task automatic t_lone_prefix();
        send(8'hAF, 1'b1);
        check("R8 no error on trailing prefix", {31'h0, err}, 32'h0);
        reg_wr(8'h41, 8'h22);
        read_chk("R8 next command parses", 8'h41, 8'h22);
        check("R1 no error on valid framing", {31'h0, err}, 32'h0);
    endtask

    task automatic t_copy();
        send(8'hAF, 1'b0);
        send(8'h6A, 1'b0);
        for (int i = 1; i <= 7; i++) send(8'(i), 1'b0);
        check("R6 cp_valid", {31'h0, cp_valid}, 32'h1);
        check("R6 cp_src", {8'h0, cp_src}, 32'h010203);
        check("R6 cp_count", {24'h0, cp_count}, 32'h04);
        check("R6 cp_dst", {8'h0, cp_dst}, 32'h050607);
        in_valid = 1'b1;
        in_data  = 8'hAF;
        for (int i = 0; i < 3; i++) begin
            check("R7 stalled", {31'h0, in_ready}, 32'h0);
            @(negedge clk);
        end
        check("R7 fields held", {8'h0, cp_src}, 32'h010203);
        cp_ready = 1'b1;
        #1;
        check("R7 stall in handshake cycle", {31'h0, in_ready}, 32'h0);
        @(negedge clk);
        cp_ready = 1'b0;
        check("R7 valid dropped", {31'h0, cp_valid}, 32'h0);
        check("R7 ready restored", {31'h0, in_ready}, 32'h1);
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        send(8'h20, 1'b0);
        send(8'h45, 1'b0);
        send(8'h3C, 1'b0);
        read_chk("R7 waiting byte taken after release", 8'h45, 8'h3C);
    endtask

    task automatic t_bad_opcode();
        send(8'hAF, 1'b0);
        send(8'h55, 1'b0);
        check("R9 error on unknown opcode", {31'h0, err}, 32'h1);
        send(8'h20, 1'b0);
        send(8'h40, 1'b0);
        send(8'h99, 1'b0);
        read_chk("R9 dropped bytes change nothing", 8'h40, 8'h77);
        reg_wr(8'h40, 8'h11);
        read_chk("R9 resync on prefix", 8'h40, 8'h11);
        check("R10 error stays", {31'h0, err}, 32'h1);
        send(8'h33, 1'b0);
        check("R1 stray byte keeps error", {31'h0, err}, 32'h1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_write();
        t_stage();
        t_decode();
        t_lone_prefix();
        t_copy();
        t_bad_opcode();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: got hung expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule